// File: doc/BRIEF.md
# Receive Fill-Character Discard Filter

This block sits between a character decoder and a receive buffer. It runs once per recovered character clock. Each incoming character carries a special/data flag and an 8-bit value, and is marked by a one-cycle valid strobe. A 2-bit policy input and a bypass input select what happens to idle fill characters (SYNC codes) and to one unwanted special code (the noise code). In buffered operation (bypass low), a write strobe carries only the characters that survive the policy. In bypass operation, every character is passed on. An "empty" flag then marks the characters that the policy rates as uninteresting.

The keep-last policy keeps only the final SYNC of each run, so that it can still serve as a delimiter. The block cannot know that a SYNC is the last of its run until the next character arrives. For that reason it holds back one character whenever a keep-last policy is in force. A three-state machine controls the holdback:

- **ST_EMPTY**: nothing is held.
- **ST_HOLD_SYNC**: a SYNC is held.
- **ST_HOLD_OTHER**: any other character is held.

The machine has four transitions:

- **capture**: ST_EMPTY goes to a hold state when a character is accepted under a holding policy.
- **re-hold**: a hold state goes to the hold state that matches a newly accepted character. The old character is released or dropped in the same cycle.
- **flush**: a hold state goes to ST_EMPTY on a cycle with no input while the policy or bypass inputs differ from the latched ones. The held character is released.
- **stay**: nothing changes.

Top module: `fill_discard_filter`

## Requirements
- R1: With policy 0 or the reserved policy 3, every valid character appears on the outputs with `out_strobe` high exactly one cycle later, carrying the same flag and value, with `out_empty` low. This holds for both bypass settings.
- R2: With policy 1 in buffered operation, a run of two or more adjacent SYNC characters produces a single write, carrying the last SYNC of the run. A SYNC is a character with the special flag at 1 and a value equal to one of the `SYNC_CODES` entries (defaults 8'hF0 and 8'hF1).
- R3: Both SYNC codes count as the same fill type, so a run that mixes them is treated as one run.
- R4: Under a holding policy, a character is written in the cycle after the next accepted character arrives. Until then the block holds it, so output lags input by one character.
- R5: With policy 2 in buffered operation, the SYNC rule of R2 applies. In addition, every character with the special flag at 1 and value `NOISE_CODE` (default 8'h05) is never written and does not break a SYNC run. A data character (flag 0) with the same value is written normally.
- R6: In bypass operation under policy 0, every character is passed with `out_empty` low.
- R7: In bypass operation under policy 1, every character is passed one character late. `out_empty` is high for every SYNC except the last of its run, and `out_empty` is never high without `out_strobe`.
- R8: In bypass operation under policy 2, every character is passed one cycle later. `out_empty` equals whether the character is a SYNC. The noise code is passed as valid.
- R9: A change of policy or bypass takes effect only while nothing is held. While a character is held and input keeps arriving, the old policy applies. The first cycle with no input releases the held character, as a valid write, and the new setting applies from then on.
- R10: After reset, `out_strobe` and `out_empty` are low and nothing is held.
- R11: A cycle with no valid input and nothing held produces no strobe in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A character is present this cycle |
| in_special | input | 1 | 1 = special character, 0 = data |
| in_value | input | DATA_W | Character value |
| mode | input | 2 | Discard policy: 0 forward, 1 keep last SYNC, 2 keep last SYNC and strip noise code, 3 as 0 |
| bypass | input | 1 | 1 = pass everything and flag instead of dropping |
| out_strobe | output | 1 | Write / output strobe |
| out_special | output | 1 | Flag of the output character |
| out_value | output | DATA_W | Value of the output character |
| out_empty | output | 1 | Bypass only: output character is uninteresting |

## Verification
Two events can land in the same clock edge:

- the release (or suppression) of the held character;
- the capture of the newly arriving one.

Policy or bypass changes add a further case: a pending change can meet a character arriving in the very cycle the change is requested.

The bench provokes both. It sends back-to-back runs of mixed SYNC codes, noise codes and data. It also changes the policy inputs while a character is held and input keeps flowing, and only later lets the input go idle. A behavioural reference model predicts the strobe, the flag, the value and the empty bit for every cycle. The model's own hold variable decides which policy governs each character.

// File: rtl/fdf_pkg.sv
package fdf_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY      = 2'd0,
        ST_HOLD_SYNC  = 2'd1,
        ST_HOLD_OTHER = 2'd2
    } hold_state_t;

    typedef enum logic [1:0] {
        RT_FORWARD  = 2'd0,
        RT_FLAG_ALL = 2'd1,
        RT_HOLD     = 2'd2
    } route_t;

    localparam logic [1:0] MODE_PASS      = 2'd0;
    localparam logic [1:0] MODE_KEEP_LAST = 2'd1;
    localparam logic [1:0] MODE_STRIP     = 2'd2;

endpackage

// File: rtl/fdf_classify.sv
module fdf_classify #(
    parameter int                         DATA_W     = 8,
    parameter int                         NUM_SYNC   = 2,
    parameter logic [NUM_SYNC*DATA_W-1:0] SYNC_CODES = 16'hF1F0,
    parameter logic [DATA_W-1:0]          NOISE_CODE = 8'h05
) (
    input  logic              special_i,
    input  logic [DATA_W-1:0] value_i,
    output logic              is_sync_o,
    output logic              is_noise_o
);

    logic [NUM_SYNC-1:0] hit;

    for (genvar g = 0; g < NUM_SYNC; g++) begin : g_sync
        assign hit[g] = special_i && (value_i == SYNC_CODES[g*DATA_W +: DATA_W]);
    end

    assign is_sync_o  = |hit;
    assign is_noise_o = special_i && (value_i == NOISE_CODE);

endmodule

// File: rtl/fdf_policy.sv
module fdf_policy
    import fdf_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       bypass_i,
    output route_t     route_o,
    output logic       drop_noise_o
);

    always_comb begin
        route_o      = RT_FORWARD;
        drop_noise_o = 1'b0;
        unique case (mode_i)
            MODE_KEEP_LAST: route_o = RT_HOLD;
            MODE_STRIP: begin
                route_o      = bypass_i ? RT_FLAG_ALL : RT_HOLD;
                drop_noise_o = !bypass_i;
            end
            default: route_o = RT_FORWARD;
        endcase
    end

endmodule

// File: rtl/fill_discard_filter.sv
module fill_discard_filter
    import fdf_pkg::*;
#(
    parameter int                         DATA_W     = 8,
    parameter int                         NUM_SYNC   = 2,
    parameter logic [NUM_SYNC*DATA_W-1:0] SYNC_CODES = 16'hF1F0,
    parameter logic [DATA_W-1:0]          NOISE_CODE = 8'h05
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_special,
    input  logic [DATA_W-1:0] in_value,
    input  logic [1:0]        mode,
    input  logic              bypass,
    output logic              out_strobe,
    output logic              out_special,
    output logic [DATA_W-1:0] out_value,
    output logic              out_empty
);

    hold_state_t       state_q, state_d;
    logic [1:0]        lmode_q;
    logic              lbyp_q;
    logic              hold_special_q;
    logic [DATA_W-1:0] hold_value_q;

    logic              strobe_q, empty_q, ospecial_q;
    logic [DATA_W-1:0] ovalue_q;
    logic              strobe_d, empty_d, ospecial_d;
    logic [DATA_W-1:0] ovalue_d;

    logic [1:0] eff_mode;
    logic       eff_byp;
    logic       in_sync, in_noise, drop_noise;
    route_t     route;
    logic       holding, cfg_change, noise_drop, take, flush;

    // While a character is held the latched setting governs; otherwise the live inputs do.
    assign holding  = (state_q != ST_EMPTY);
    assign eff_mode = holding ? lmode_q : mode;
    assign eff_byp  = holding ? lbyp_q  : bypass;

    fdf_classify #(
        .DATA_W     (DATA_W),
        .NUM_SYNC   (NUM_SYNC),
        .SYNC_CODES (SYNC_CODES),
        .NOISE_CODE (NOISE_CODE)
    ) u_classify (
        .special_i  (in_special),
        .value_i    (in_value),
        .is_sync_o  (in_sync),
        .is_noise_o (in_noise)
    );

    fdf_policy u_policy (
        .mode_i       (eff_mode),
        .bypass_i     (eff_byp),
        .route_o      (route),
        .drop_noise_o (drop_noise)
    );

    assign noise_drop = drop_noise && in_noise;
    assign take       = in_valid && (route == RT_HOLD) && !noise_drop;
    assign cfg_change = holding && ((mode != lmode_q) || (bypass != lbyp_q));
    assign flush      = !in_valid && cfg_change;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (take) state_d = in_sync ? ST_HOLD_SYNC : ST_HOLD_OTHER;
            end
            ST_HOLD_SYNC, ST_HOLD_OTHER: begin
                if (take)       state_d = in_sync ? ST_HOLD_SYNC : ST_HOLD_OTHER;
                else if (flush) state_d = ST_EMPTY;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // Output decisions
    always_comb begin
        strobe_d   = 1'b0;
        empty_d    = 1'b0;
        ospecial_d = ospecial_q;
        ovalue_d   = ovalue_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (in_valid && route == RT_FORWARD) begin
                    strobe_d   = 1'b1;
                    ospecial_d = in_special;
                    ovalue_d   = in_value;
                end else if (in_valid && route == RT_FLAG_ALL) begin
                    strobe_d   = 1'b1;
                    empty_d    = in_sync;
                    ospecial_d = in_special;
                    ovalue_d   = in_value;
                end
            end
            ST_HOLD_SYNC: begin
                if (take && in_sync) begin
                    // held SYNC is not the last of its run
                    if (eff_byp) begin
                        strobe_d   = 1'b1;
                        empty_d    = 1'b1;
                        ospecial_d = hold_special_q;
                        ovalue_d   = hold_value_q;
                    end
                end else if (take || flush) begin
                    strobe_d   = 1'b1;
                    ospecial_d = hold_special_q;
                    ovalue_d   = hold_value_q;
                end
            end
            ST_HOLD_OTHER: begin
                if (take || flush) begin
                    strobe_d   = 1'b1;
                    ospecial_d = hold_special_q;
                    ovalue_d   = hold_value_q;
                end
            end
            default: strobe_d = 1'b0;
        endcase
    end

    // State and hold register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q        <= ST_EMPTY;
            lmode_q        <= MODE_PASS;
            lbyp_q         <= 1'b0;
            hold_special_q <= 1'b0;
            hold_value_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                hold_special_q <= in_special;
                hold_value_q   <= in_value;
                lmode_q        <= eff_mode;
                lbyp_q         <= eff_byp;
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q   <= 1'b0;
            empty_q    <= 1'b0;
            ospecial_q <= 1'b0;
            ovalue_q   <= '0;
        end else begin
            strobe_q   <= strobe_d;
            empty_q    <= empty_d;
            ospecial_q <= ospecial_d;
            ovalue_q   <= ovalue_d;
        end
    end

    assign out_strobe  = strobe_q;
    assign out_empty   = empty_q;
    assign out_special = ospecial_q;
    assign out_value   = ovalue_q;

endmodule

// File: rtl/fdf_checker.sv
module fdf_checker
    import fdf_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] NOISE_CODE = 8'h05
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_special,
    input logic [DATA_W-1:0] in_value,
    input logic [1:0]        mode,
    input logic              bypass,
    input logic              out_strobe,
    input logic [DATA_W-1:0] out_value,
    input logic              out_empty,
    input hold_state_t       state
);

    assert_empty_with_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_empty |-> out_strobe);

    assert_forward_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && state == ST_EMPTY && (mode == 2'd0 || mode == 2'd3))
        |=> (out_strobe && !out_empty && out_value == $past(in_value)));

    assert_noise_stripped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_special && in_value == NOISE_CODE && !bypass && mode == 2'd2
         && state == ST_EMPTY) |=> !out_strobe);

    assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && state == ST_EMPTY) |=> !out_strobe);

    assert_release_on_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_special && state != ST_EMPTY) |=> out_strobe);

endmodule

bind fill_discard_filter fdf_checker #(
    .DATA_W     (DATA_W),
    .NOISE_CODE (NOISE_CODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_special (in_special),
    .in_value   (in_value),
    .mode       (mode),
    .bypass     (bypass),
    .out_strobe (out_strobe),
    .out_value  (out_value),
    .out_empty  (out_empty),
    .state      (state_q)
);

// File: tb/fill_discard_filter_tb.sv
`timescale 1ns/1ps
module fill_discard_filter_tb;

    localparam logic [7:0] SA = 8'hF0;
    localparam logic [7:0] SB = 8'hF1;
    localparam logic [7:0] NZ = 8'h05;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_special = 1'b0, bypass = 1'b0;
    logic [7:0] in_value = '0;
    logic [1:0] mode = 2'd0;
    logic       out_strobe, out_special, out_empty;
    logic [7:0] out_value;

    int    n_tests = 0, n_fail = 0;
    string cur_req = "R10";
    bit    done = 0;

    // reference model state
    bit       m_held = 0, m_hsp = 0;
    bit [7:0] m_hval = 0;
    int       m_pol = 0;
    bit       m_byp = 0;
    bit       e_str, e_emp, e_sp;
    bit [7:0] e_val;

    always #2 clk = ~clk;

    fill_discard_filter u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_special(in_special),
        .in_value(in_value), .mode(mode), .bypass(bypass),
        .out_strobe(out_strobe), .out_special(out_special),
        .out_value(out_value), .out_empty(out_empty)
    );

    function automatic bit is_fill(bit s, bit [7:0] v);
        return s && (v == SA || v == SB);
    endfunction

    task automatic emit(bit s, bit [7:0] v, bit emp);
        e_str = 1; e_sp = s; e_val = v; e_emp = emp;
    endtask

    // Behavioural expectation for one clock, from the inputs applied in that clock.
    task automatic model_step(bit v, bit s, bit [7:0] val, int md, bit by);
        int  pol;
        bit  pb;
        e_str = 0; e_emp = 0;
        if (m_held && !v && (md != m_pol || by != m_byp)) begin
            emit(m_hsp, m_hval, 0);
            m_held = 0;
        end else if (v) begin
            pol = m_held ? m_pol : ((md == 3) ? 0 : md);
            pb  = m_held ? m_byp : by;
            if (pol == 0) emit(s, val, 0);
            else if (pb && pol == 2) emit(s, val, is_fill(s, val));
            else if (!pb && pol == 2 && s && val == NZ) begin end
            else begin
                if (m_held) begin
                    if (is_fill(m_hsp, m_hval) && is_fill(s, val)) begin
                        if (pb) emit(m_hsp, m_hval, 1);
                    end else emit(m_hsp, m_hval, 0);
                end
                m_held = 1; m_hsp = s; m_hval = val; m_pol = pol; m_byp = pb;
            end
        end
    endtask

    task automatic compare();
        n_tests++;
        if (out_strobe !== e_str || out_empty !== e_emp ||
            (e_str && (out_special !== e_sp || out_value !== e_val))) begin
            n_fail++;
            $display("FAIL %s: got str=%0b emp=%0b sp=%0b val=%02h, expected str=%0b emp=%0b sp=%0b val=%02h",
                     cur_req, out_strobe, out_empty, out_special, out_value,
                     e_str, e_emp, e_sp, e_val);
        end
    endtask

    task automatic cyc(bit v, bit s, bit [7:0] val);
        in_valid = v; in_special = s; in_value = val;
        @(posedge clk);
        @(negedge clk);
        model_step(v, s, val, int'(mode), bypass);
        compare();
    endtask

    task automatic send(bit s, bit [7:0] val); cyc(1, s, val); endtask
    task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, 0, 8'h00); endtask
    task automatic cfg(int md, bit by); mode = md[1:0]; bypass = by; idle(2); endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R10"; e_str = 0; e_emp = 0; compare();

        // R1: plain forwarding, policies 0 and 3
        cur_req = "R1"; cfg(0, 0);
        send(0, 8'h11); send(1, SA); send(1, SA); send(1, NZ); send(0, 8'h22);
        cfg(3, 0);
        send(1, SB); send(1, SB); send(0, 8'h33);
        cur_req = "R11"; idle(4);

        // R2/R3/R4: keep last SYNC, mixed codes, one-character lag
        cur_req = "R2"; cfg(1, 0);
        send(0, 8'h41); send(1, SA); send(1, SA); send(1, SA); send(0, 8'h42);
        cur_req = "R3";
        send(1, SA); send(1, SB); send(1, SA); send(1, SB); send(0, 8'h43);
        cur_req = "R4";
        send(1, SB); send(0, 8'h44); send(1, 8'h55); send(0, 8'h45);

        // R5: strip noise code, noise does not split a run
        cur_req = "R5"; cfg(2, 0);
        send(1, SA); send(1, NZ); send(1, SB); send(0, NZ); send(1, NZ);
        send(0, 8'h46); send(1, SA); send(0, 8'h47);

        // R6-R8: bypass flags
        cur_req = "R6"; cfg(0, 1);
        send(1, SA); send(1, SA); send(1, NZ); send(0, 8'h48);
        cur_req = "R7"; cfg(1, 1);
        send(1, SA); send(1, SB); send(1, SA); send(0, 8'h49); send(1, SB); send(1, NZ);
        cur_req = "R8"; cfg(2, 1);
        send(1, SA); send(1, SB); send(1, NZ); send(0, 8'h4A); send(1, SA);

        // R9: policy change deferred while held and input keeps flowing
        cur_req = "R9"; cfg(1, 0);
        send(1, SA);
        mode = 2'd0;
        send(1, SB); send(1, SA); send(0, 8'h4B); send(1, SA);
        idle(1);
        send(1, SA); send(1, SA); send(0, 8'h4C);
        idle(2);

        // randomised traffic across all settings
        for (int c = 0; c < 7; c++) begin
            int md;
            bit by;
            md = (c < 4) ? c : c - 4;
            by = (c >= 4);
            case (c)
                0, 3: cur_req = "R1";
                1: cur_req = "R2";
                2: cur_req = "R5";
                4: cur_req = "R6";
                5: cur_req = "R7";
                default: cur_req = "R8";
            endcase
            cfg(md, by);
            for (int i = 0; i < 250; i++) begin
                int k;
                k = int'($urandom_range(0, 7));
                if (k == 0) idle(1);
                else if (k <= 2) send(1, SA);
                else if (k == 3) send(1, SB);
                else if (k == 4) send(1, NZ);
                else if (k == 5) send(1, 8'($urandom));
                else send(0, 8'($urandom));
            end
        end
        idle(2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule